// File: doc/BRIEF.md
# USB Device Global Interrupt Status Logic

This block gathers eight global USB device events into one latched status register. Each event arrives as a one-cycle pulse from logic outside the block: bus reset, frame start, pseudo frame start, suspend, resume, full-to-high-speed change, DMA status change and endpoint-0 setup arrival. An event is recorded only if its enable bit is already 1 in the cycle the pulse occurs. An event that arrives while its enable bit is 0 is lost for good. Software reads the status through a small word-addressed register port. It clears bits by writing ones to a separate write-only clear register.

A combined interrupt line is a registered OR of all status bits. Two synchronous reset inputs give different starting states. The master reset clears everything. A USB bus reset leaves only the bus-reset status bit set and keeps the enable register as it was.

Register map (word index on `regAddr`): 0 is enable (read/write), 1 is clear (write-only), 2 is status (read-only), and 3 reads as zero.

Top module: `usb_evt_status`

## Requirements
- R1: Status bit positions are: bit 0 bus reset, bit 1 frame start, bit 2 pseudo frame start, bit 3 suspend, bit 4 resume, bit 5 full-to-high-speed change, bit 6 DMA status change, bit 7 endpoint-0 setup. Event input `evtPulse[i]` feeds status bit i.
- R2: A pulse on `evtPulse[i]` sets status bit i at the next clock edge only if enable bit i is 1 in that same cycle. A pulse that arrives while enable bit i is 0 is not recorded, even after the enable bit is later set.
- R3: Writing 1 to bit i of the clear register (address 1) clears status bit i at the next edge. Writing 0 leaves the bit unchanged. Writes to the status address (2) have no effect.
- R4: While `rstMaster` is high, the status register, the enable register and `irqOut` are all 0 after the clock edge.
- R5: A cycle with `busRst` high (and `rstMaster` low) loads status with 0x01 and leaves the enable register unchanged. Event pulses in that cycle are not recorded.
- R6: The high-speed status bit (bit 5) is set only by its own event input. A suspend event (bit 3) never sets bit 5.
- R7: Read data bits 31:8 are always 0. Write data bits 31:8 are ignored (enable reads back only bits 7:0).
- R8: If an enabled event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R9: `irqOut` is registered. It is 1 in the cycle after any status bit is 1, and 0 in the cycle after all status bits are 0.
- R10: The clear address and address 3 read as 0.
- R11: A write to address 0 loads enable bits 7:0 at the next edge, and they read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstMaster | input | 1 | Synchronous master reset, active high |
| busRst | input | 1 | Synchronous USB bus reset, active high |
| evtPulse | input | 8 | One-cycle event pulses, one per status bit |
| regAddr | input | 2 | Word address of the register port |
| regWrEn | input | 1 | Write strobe for the register port |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| irqOut | output | 1 | Registered OR of the status bits |

## Verification
The case hardest to reach from the ports is an event and a clear landing on the same bit in the same cycle. The event pulse and the clear-register write have to be driven within the same clock period. The bench does this directly by raising `evtPulse` and the clear write together. Most of the stimulus is a sweep over all 256 enable values, each paired with two different event patterns. This shows arithmetically that the captured status always equals event AND enable, and that a later enable never revives an event that was missed.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;
  localparam int NUM_EVT = 8;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 2;

  localparam int ADDR_EN   = 0;
  localparam int ADDR_CLR  = 1;
  localparam int ADDR_STAT = 2;

  localparam int EVT_BUSRST = 0;
  localparam int EVT_SOF    = 1;
  localparam int EVT_PSOF   = 2;
  localparam int EVT_SUSP   = 3;
  localparam int EVT_RESUME = 4;
  localparam int EVT_HS     = 5;
  localparam int EVT_DMA    = 6;
  localparam int EVT_SETUP  = 7;

  typedef struct packed {
    logic enWr;
    logic clrWr;
  } ctlStrobe_t;
endpackage

// File: rtl/usb_evt_ctrl.sv
module usb_evt_ctrl
  import usb_evt_pkg::*;
#(
  parameter int NUM_EVT_P = NUM_EVT,
  parameter int DATA_W_P  = DATA_W,
  parameter int ADDR_W_P  = ADDR_W
) (
  input  logic [ADDR_W_P-1:0]  regAddr,
  input  logic                 regWrEn,
  input  logic [NUM_EVT_P-1:0] enableQ,
  input  logic [NUM_EVT_P-1:0] statusQ,
  output ctlStrobe_t           strobe,
  output logic [DATA_W_P-1:0]  regRdData
);
  localparam logic [ADDR_W_P-1:0] A_EN   = ADDR_W_P'(ADDR_EN);
  localparam logic [ADDR_W_P-1:0] A_CLR  = ADDR_W_P'(ADDR_CLR);
  localparam logic [ADDR_W_P-1:0] A_STAT = ADDR_W_P'(ADDR_STAT);

  always_comb begin
    strobe.enWr  = regWrEn && (regAddr == A_EN);
    strobe.clrWr = regWrEn && (regAddr == A_CLR);
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == A_EN)
      regRdData[NUM_EVT_P-1:0] = enableQ;
    else if (regAddr == A_STAT)
      regRdData[NUM_EVT_P-1:0] = statusQ;
  end
endmodule

// File: rtl/usb_evt_dp.sv
module usb_evt_dp
  import usb_evt_pkg::*;
#(
  parameter int NUM_EVT_P = NUM_EVT
) (
  input  logic                 clk,
  input  logic                 rstMaster,
  input  logic                 busRst,
  input  ctlStrobe_t           strobe,
  input  logic [NUM_EVT_P-1:0] wrBits,
  input  logic [NUM_EVT_P-1:0] evtPulse,
  output logic [NUM_EVT_P-1:0] enableQ,
  output logic [NUM_EVT_P-1:0] statusQ,
  output logic                 irqQ
);
  localparam logic [NUM_EVT_P-1:0] BUS_RST_VAL = NUM_EVT_P'(1) << EVT_BUSRST;

  logic [NUM_EVT_P-1:0] statusNext;

  for (genvar i = 0; i < NUM_EVT_P; i++) begin : g_bit
    logic setBit;
    logic clrBit;
    assign setBit = evtPulse[i] & enableQ[i];
    assign clrBit = strobe.clrWr & wrBits[i];
    assign statusNext[i] = setBit | (statusQ[i] & ~clrBit);
  end

  always_ff @(posedge clk) begin
    if (rstMaster) begin
      enableQ <= '0;
      statusQ <= '0;
      irqQ    <= 1'b0;
    end else begin
      if (strobe.enWr)
        enableQ <= wrBits;
      if (busRst)
        statusQ <= BUS_RST_VAL;
      else
        statusQ <= statusNext;
      irqQ <= |statusQ;
    end
  end
endmodule

// File: rtl/usb_evt_status.sv
module usb_evt_status
  import usb_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rstMaster,
  input  logic              busRst,
  input  logic [NUM_EVT-1:0] evtPulse,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  ctlStrobe_t         strobe;
  logic [NUM_EVT-1:0] enableQ;
  logic [NUM_EVT-1:0] statusQ;

  usb_evt_ctrl #(.NUM_EVT_P(NUM_EVT), .DATA_W_P(DATA_W), .ADDR_W_P(ADDR_W)) uCtrl (
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .enableQ  (enableQ),
    .statusQ  (statusQ),
    .strobe   (strobe),
    .regRdData(regRdData)
  );

  usb_evt_dp #(.NUM_EVT_P(NUM_EVT)) uDp (
    .clk      (clk),
    .rstMaster(rstMaster),
    .busRst   (busRst),
    .strobe   (strobe),
    .wrBits   (regWrData[NUM_EVT-1:0]),
    .evtPulse (evtPulse),
    .enableQ  (enableQ),
    .statusQ  (statusQ),
    .irqQ     (irqOut)
  );
endmodule

// File: rtl/usb_evt_chk.sv
module usb_evt_chk
  import usb_evt_pkg::*;
(
  input logic               clk,
  input logic               rstMaster,
  input logic               busRst,
  input logic [NUM_EVT-1:0] evtPulse,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regWrEn,
  input logic [DATA_W-1:0]  regWrData,
  input logic [DATA_W-1:0]  regRdData,
  input logic               irqOut,
  input logic [NUM_EVT-1:0] enableQ,
  input logic [NUM_EVT-1:0] statusQ
);
  logic               enHit;
  logic               clrHit;
  logic [NUM_EVT-1:0] captured;
  assign enHit    = regWrEn && (regAddr == ADDR_W'(ADDR_EN));
  assign clrHit   = regWrEn && (regAddr == ADDR_W'(ADDR_CLR));
  assign captured = evtPulse & enableQ;

  assert_capture_R2: assert property (@(posedge clk) disable iff (rstMaster)
    (!busRst && captured != '0) |=> ((statusQ & $past(captured)) == $past(captured)));

  assert_no_stray_set_R2: assert property (@(posedge clk) disable iff (rstMaster)
    (!busRst) |=> ((statusQ & ~$past(statusQ) & ~$past(captured)) == '0));

  assert_clear_R3: assert property (@(posedge clk) disable iff (rstMaster)
    (clrHit && !busRst) |=> ((statusQ & $past(regWrData[NUM_EVT-1:0] & ~captured)) == '0));

  assert_master_reset_R4: assert property (@(posedge clk)
    rstMaster |=> (statusQ == '0 && enableQ == '0 && !irqOut));

  assert_bus_reset_R5: assert property (@(posedge clk) disable iff (rstMaster)
    busRst |=> (statusQ == NUM_EVT'(1) && (enHit ? 1'b1 : 1'b1)));

  assert_bus_reset_keeps_en_R5: assert property (@(posedge clk) disable iff (rstMaster)
    (busRst && !enHit) |=> (enableQ == $past(enableQ)));

  assert_reserved_read_R7: assert property (@(posedge clk) disable iff (rstMaster)
    regRdData[DATA_W-1:NUM_EVT] == '0);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rstMaster)
    (clrHit && !busRst && captured != '0) |=> ((statusQ & $past(captured)) == $past(captured)));

  assert_irq_high_R9: assert property (@(posedge clk) disable iff (rstMaster)
    (statusQ != '0) |=> irqOut);

  assert_irq_low_R9: assert property (@(posedge clk) disable iff (rstMaster)
    (statusQ == '0) |=> !irqOut);

  assert_enable_write_R11: assert property (@(posedge clk) disable iff (rstMaster)
    enHit |=> (enableQ == $past(regWrData[NUM_EVT-1:0])));
endmodule

bind usb_evt_status usb_evt_chk uChk (
  .clk      (clk),
  .rstMaster(rstMaster),
  .busRst   (busRst),
  .evtPulse (evtPulse),
  .regAddr  (regAddr),
  .regWrEn  (regWrEn),
  .regWrData(regWrData),
  .regRdData(regRdData),
  .irqOut   (irqOut),
  .enableQ  (enableQ),
  .statusQ  (statusQ)
);

// File: tb/sim_usb_evt_status.sv
`timescale 1ns/1ps
module sim_usb_evt_status;
  logic        clk = 1'b0;
  logic        rstMaster = 1'b1;
  logic        busRst = 1'b0;
  logic [7:0]  evtPulse = '0;
  logic [1:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  usb_evt_status u0 (
    .clk(clk), .rstMaster(rstMaster), .busRst(busRst), .evtPulse(evtPulse),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic pulse(input logic [7:0] e);
    evtPulse = e;
    tick();
    evtPulse = '0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    tick(); tick();
    rstMaster = 1'b0;
    // R4: master reset state
    readReg(2'd2, d); check("R4 status after master reset", d, 32'h0);
    readReg(2'd0, d); check("R4 enable after master reset", d, 32'h0);
    check("R4 irq after master reset", {31'b0, irqOut}, 32'h0);

    // R1 R2 R9: sweep every enable value with two event patterns
    for (int e = 0; e < 256; e++) begin
      for (int k = 0; k < 2; k++) begin
        logic [7:0] ev;
        ev = (k == 0) ? 8'(e ^ 8'h5A) : 8'hFF;
        writeReg(2'd0, 32'(e));
        pulse(ev);
        readReg(2'd2, d);
        check("R2 captured = event AND enable", d, 32'(ev & 8'(e)));
        tick();
        check("R9 irq one cycle after set", {31'b0, irqOut}, {31'b0, |(ev & 8'(e))});
        writeReg(2'd1, 32'hFF);
        readReg(2'd2, d);
        check("R3 clear all", d, 32'h0);
        tick();
        check("R9 irq low after clear", {31'b0, irqOut}, 32'h0);
      end
    end

    // R1: single-bit positions
    writeReg(2'd0, 32'hFF);
    for (int b = 0; b < 8; b++) begin
      pulse(8'(1 << b));
      readReg(2'd2, d);
      check("R1 event i sets bit i", d, 32'(1 << b));
      writeReg(2'd1, 32'(1 << b));
    end

    // R2: lost event stays lost
    writeReg(2'd0, 32'h0);
    pulse(8'h10);
    writeReg(2'd0, 32'h10);
    readReg(2'd2, d); check("R2 disabled event lost", d, 32'h0);

    // R6: suspend never sets high-speed bit
    writeReg(2'd0, 32'hFF);
    pulse(8'h08);
    readReg(2'd2, d); check("R6 suspend sets only bit3", d, 32'h08);

    // R3: write 0 to clear has no effect; status write ignored
    writeReg(2'd1, 32'h00);
    readReg(2'd2, d); check("R3 write0 clear no effect", d, 32'h08);
    writeReg(2'd2, 32'hFF);
    readReg(2'd2, d); check("R3 status write ignored", d, 32'h08);
    writeReg(2'd1, 32'h08);

    // R8: set beats clear
    evtPulse = 8'h08;
    regAddr = 2'd1; regWrData = 32'hFF; regWrEn = 1'b1;
    tick();
    evtPulse = '0; regWrEn = 1'b0;
    readReg(2'd2, d); check("R8 set wins over clear", d, 32'h08);

    // R10: clear and spare addresses read 0
    readReg(2'd1, d); check("R10 clear reads 0", d, 32'h0);
    readReg(2'd3, d); check("R10 addr3 reads 0", d, 32'h0);

    // R7 R11: reserved write bits ignored
    writeReg(2'd0, 32'hFFFF_FF3C);
    readReg(2'd0, d); check("R7 R11 enable readback", d, 32'h3C);

    // R5: bus reset
    pulse(8'h30);
    busRst = 1'b1;
    evtPulse = 8'h04;
    tick();
    busRst = 1'b0; evtPulse = '0;
    readReg(2'd2, d); check("R5 bus reset status", d, 32'h01);
    readReg(2'd0, d); check("R5 enable kept", d, 32'h3C);
    tick();
    check("R9 irq after bus reset", {31'b0, irqOut}, 32'h1);

    // R4: master reset again
    rstMaster = 1'b1;
    tick();
    rstMaster = 1'b0;
    readReg(2'd2, d); check("R4 status cleared", d, 32'h0);
    readReg(2'd0, d); check("R4 enable cleared", d, 32'h0);
    check("R4 irq cleared", {31'b0, irqOut}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule